// File: doc/BRIEF.md
# Interrupt-Router Register Window

This block holds the programmable state of an interrupt router and gives software access to it through a two-address window on a 32-bit bus. Software first stores a register number in a select register. It then reads or writes the chosen internal register through a data port. The internal registers are a unit identifier, a read-only version word, an arbitration identifier and a table of 64-bit routing entries. Each routing entry is reached as a pair of 32-bit registers. The block's outputs present every table entry and both identifiers to the routing logic that follows, so that logic reads the configuration without any bus traffic.

Each request lasts one cycle. The block registers its response and presents it on the next cycle. A write takes effect at the clock edge of the request. Each entry has fields in fixed places: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13, trigger in 15, mask in 16 and destination in 63:56. The block clears every other bit when software writes that half of the entry.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select register is 0, the unit ID and the arbitration ID both equal the RESET_ID parameter, every table entry reads low half 0x00010000 (mask set) and high half 0, and the sticky undefined-access flag is 0.
- R2: Every request receives exactly one response, with rsp_valid high on the cycle after the request. The response carries read data in rsp_rdata. A write response returns zero data.
- R3: Offset 0 is the select register. A write stores wdata[7:0], and a read returns the stored number zero-extended to 32 bits.
- R4: A request to any offset other than 0 or 16, or a request whose byte enables are not 4'b1111, gets a response with rsp_err high and rdata 0. Such a request changes no state.
- R5: Register 0x00 holds the unit ID. A write through offset 16 takes wdata[31:24]. A read returns the ID in bits 31:24 with every other bit zero.
- R6: Register 0x01 is read-only. It returns ENTRIES-1 in bits 23:16 and the VERSION parameter in bits 7:0. Writes to it change nothing and do not set the undefined flag.
- R7: Register 0x02 holds the arbitration ID and uses the same bit placement and write behaviour as the unit ID.
- R8: Register 0x10+2k is the low half of entry k and register 0x11+2k is its high half, for k from 0 to ENTRIES-1.
- R9: A write to a low half stores wdata AND 0x0001AFFF. A write to a high half stores wdata AND 0xFF000000.
- R10: A data-port access to a register number in 0x03..0x0F or at or above 0x10+2*ENTRIES reads 0 and leaves all state unchanged. It sets undef_err, which then stays high until reset. It does not raise rsp_err.
- R11: tbl_entries bits [64k+63:64k] show entry k, and unit_id and arb_id show the two identifiers. Each output reflects a write from the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFFSET_W | Byte offset within the window |
| req_be | input | 4 | Byte enables; only 4'b1111 is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 32 | Read data |
| undef_err | output | 1 | Sticky flag for accesses to undefined register numbers |
| unit_id | output | 8 | Current unit identifier |
| arb_id | output | 8 | Current arbitration identifier |
| tbl_entries | output | 64*ENTRIES | All routing entries, entry k at bits 64k+63:64k |

## Verification
The data port is tried with all-ones patterns, so that the written value shows which bits each register keeps and which it clears. It is also tried with mixed patterns, which show whether the ID fields come from the top byte. The select register is set to the first and last table halves and to one entry in the middle, which shows whether the even/odd half choice and the index arithmetic are right. Writes to the read-only version register and to undefined numbers just outside the table are followed by read-backs and output checks, which tell an ignored write apart from a stray one. Bad offsets and partial byte enables are then followed by reads of the select register, which show that an errored request changed nothing.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int          ENTRIES  = 24,
  parameter int          OFFSET_W = 5,
  parameter logic [7:0]  RESET_ID = 8'h0E,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [OFFSET_W-1:0]   req_offset,
  input  logic [3:0]            req_be,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rsp_rdata,
  output logic                  undef_err,
  output logic [7:0]            unit_id,
  output logic [7:0]            arb_id,
  output logic [64*ENTRIES-1:0] tbl_entries
);

  localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
  localparam logic [31:0] LO_RESET = 32'h0001_0000;
  localparam logic [8:0]  TBL_END  = 9'(16 + 2 * ENTRIES);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(ENTRIES - 1), 8'h00, VERSION};

  logic [7:0]  sel_q, id_q, arb_q;
  logic [31:0] tbl_lo [ENTRIES];
  logic [31:0] tbl_hi [ENTRIES];

  logic        off_sel, off_data, acc_ok;
  logic        is_id, is_ver, is_arb, is_tbl, is_undef;
  logic [7:0]  tbl_rel;
  logic [6:0]  tbl_k;
  logic        wr_data, rd_data;
  logic [31:0] rd_tbl, rd_word;

  assign off_sel  = req_offset == OFFSET_W'(0);
  assign off_data = req_offset == OFFSET_W'(16);
  assign acc_ok   = (req_be == 4'hF) && (off_sel || off_data);

  assign is_id    = sel_q == 8'h00;
  assign is_ver   = sel_q == 8'h01;
  assign is_arb   = sel_q == 8'h02;
  assign is_tbl   = (sel_q >= 8'h10) && ({1'b0, sel_q} < TBL_END);
  assign is_undef = !(is_id || is_ver || is_arb || is_tbl);
  assign tbl_rel  = sel_q - 8'h10;
  assign tbl_k    = tbl_rel[7:1];

  assign wr_data  = req_valid && acc_ok && off_data && req_write;
  assign rd_data  = req_valid && acc_ok && off_data && !req_write;

  always_comb begin
    rd_tbl = '0;
    for (int k = 0; k < ENTRIES; k++)
      if (tbl_k == 7'(k)) rd_tbl = sel_q[0] ? tbl_hi[k] : tbl_lo[k];
  end

  always_comb begin
    rd_word = '0;
    if (off_sel)          rd_word = {24'h0, sel_q};
    else if (is_id)       rd_word = {id_q, 24'h0};
    else if (is_ver)      rd_word = VER_WORD;
    else if (is_arb)      rd_word = {arb_q, 24'h0};
    else if (is_tbl)      rd_word = rd_tbl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= RESET_ID;
      arb_q     <= RESET_ID;
      undef_err <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && acc_ok && !req_write) ? rd_word : 32'h0;
      if (req_valid && acc_ok && off_sel && req_write) sel_q <= req_wdata[7:0];
      if (wr_data && is_id)  id_q  <= req_wdata[31:24];
      if (wr_data && is_arb) arb_q <= req_wdata[31:24];
      if ((wr_data || rd_data) && is_undef) undef_err <= 1'b1;
    end
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    logic hit;
    assign hit = wr_data && is_tbl && (tbl_k == 7'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl_lo[k] <= LO_RESET;
        tbl_hi[k] <= '0;
      end else if (hit) begin
        if (sel_q[0]) tbl_hi[k] <= req_wdata & HI_KEEP;
        else          tbl_lo[k] <= req_wdata & LO_KEEP;
      end
    end

    assign tbl_entries[64*k +: 64] = {tbl_hi[k], tbl_lo[k]};

    a_r9_lo_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_lo[k] & ~LO_KEEP) == 32'h0);
    a_r9_hi_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_hi[k] & ~HI_KEEP) == 32'h0);
  end

  assign unit_id = id_q;
  assign arb_id  = arb_q;

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r4_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'h0);
  a_r4_bad_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> ($stable(sel_q) && $stable(id_q) && $stable(arb_q)));
  a_r10_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    undef_err |=> undef_err);
  a_r6_version_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && is_ver) |=> rsp_rdata == VER_WORD);

endmodule

// File: tb/tb_irq_route_regs.sv
`timescale 1ns/1ps
module tb_irq_route_regs;
  localparam int ENT = 24;
  localparam int OW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [OW-1:0] req_offset = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, undef_err;
  logic [31:0] rsp_rdata;
  logic [7:0] unit_id, arb_id;
  logic [64*ENT-1:0] tbl_entries;

  int checks = 0;
  int errors = 0;

  irq_route_regs #(.ENTRIES(ENT), .OFFSET_W(OW), .RESET_ID(8'h0E), .VERSION(8'h11)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .undef_err(undef_err), .unit_id(unit_id), .arb_id(arb_id), .tbl_entries(tbl_entries));

  always #10 clk = ~clk;

  // {tag, write, offset, be, wdata, exp_err, exp_rdata}
  localparam int NV = 27;
  localparam logic [78:0] VEC [NV] = '{
    {4'd3, 1'b0, 5'd0,  4'hF, 32'h0,        1'b0, 32'h0000_0000}, // R3 select reads 0
    {4'd5, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h0E00_0000}, // R5 reset ID
    {4'd3, 1'b1, 5'd0,  4'hF, 32'h1,        1'b0, 32'h0},
    {4'd6, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h0017_0011}, // R6 version
    {4'd6, 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF,1'b0, 32'h0},
    {4'd6, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h0017_0011}, // R6 write ignored
    {4'd3, 1'b1, 5'd0,  4'hF, 32'h0,        1'b0, 32'h0},
    {4'd5, 1'b1, 5'd16, 4'hF, 32'hA512_3456,1'b0, 32'h0},
    {4'd5, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'hA500_0000}, // R5
    {4'd3, 1'b1, 5'd0,  4'hF, 32'h2,        1'b0, 32'h0},
    {4'd7, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h0E00_0000}, // R7 arb reset = ID
    {4'd7, 1'b1, 5'd16, 4'hF, 32'h3C00_0001,1'b0, 32'h0},
    {4'd7, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h3C00_0000}, // R7
    {4'd3, 1'b1, 5'd0,  4'hF, 32'h10,       1'b0, 32'h0},
    {4'd1, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h0001_0000}, // R1 mask set
    {4'd9, 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF,1'b0, 32'h0},
    {4'd9, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h0001_AFFF}, // R9 low keep
    {4'd3, 1'b1, 5'd0,  4'hF, 32'h11,       1'b0, 32'h0},
    {4'd9, 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF,1'b0, 32'h0},
    {4'd9, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'hFF00_0000}, // R9 high keep
    {4'd3, 1'b1, 5'd0,  4'hF, 32'h3F,       1'b0, 32'h0},
    {4'd8, 1'b1, 5'd16, 4'hF, 32'h1234_5678,1'b0, 32'h0},
    {4'd8, 1'b0, 5'd16, 4'hF, 32'h0,        1'b0, 32'h1200_0000}, // R8 last entry high
    {4'd4, 1'b0, 5'd4,  4'hF, 32'h0,        1'b1, 32'h0},         // R4 bad offset
    {4'd4, 1'b1, 5'd0,  4'h3, 32'h55,       1'b1, 32'h0},         // R4 partial write
    {4'd4, 1'b0, 5'd0,  4'hF, 32'h0,        1'b0, 32'h0000_003F}, // R4 select unchanged
    {4'd4, 1'b0, 5'd16, 4'h1, 32'h0,        1'b1, 32'h0}          // R4 partial read
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [OW-1:0] off, input logic [3:0] be,
                        input logic [31:0] wd, output logic vld, output logic err,
                        output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    vld = rsp_valid; err = rsp_err; rd = rsp_rdata;
  endtask

  initial begin
    logic v, e;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 undef_err", 64'(undef_err), 64'h0);
    check("R1 unit_id", 64'(unit_id), 64'h0E);
    check("R1 arb_id", 64'(arb_id), 64'h0E);
    for (int k = 0; k < ENT; k++)
      check("R1 entry", tbl_entries[64*k +: 64], 64'h0000_0000_0001_0000);
    check("R2 idle no rsp", 64'(rsp_valid), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] t;
      t = VEC[i];
      access(t[74], t[73:69], t[68:65], t[64:33], v, e, d);
      checks++;
      if (!v || e !== t[32] || d !== t[31:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d actual vld=%b err=%b rd=%h expected err=%b rd=%h",
                 t[78:75], i, v, e, d, t[32], t[31:0]);
      end
    end

    @(negedge clk);
    check("R2 rsp drops when idle", 64'(rsp_valid), 64'h0);
    // R11 outputs reflect writes
    check("R11 entry0", tbl_entries[63:0], 64'hFF00_0000_0001_AFFF);
    check("R11 entry23", tbl_entries[64*23 +: 64], 64'h1200_0000_0001_0000);
    check("R11 unit_id", 64'(unit_id), 64'hA5);
    check("R11 arb_id", 64'(arb_id), 64'h3C);
    check("R10 flag clear after defined accesses", 64'(undef_err), 64'h0);

    // R8 mid-table entry 10 high half (register 0x25)
    access(1'b1, 5'd0, 4'hF, 32'h25, v, e, d);
    access(1'b1, 5'd16, 4'hF, 32'hABCD_EF01, v, e, d);
    check("R8 entry10 high", tbl_entries[64*10 +: 64], 64'hAB00_0000_0001_0000);
    access(1'b1, 5'd0, 4'hF, 32'h24, v, e, d);
    access(1'b1, 5'd16, 4'hF, 32'h0000_0123, v, e, d);
    check("R8 entry10 low", tbl_entries[64*10 +: 64], 64'hAB00_0000_0000_0123);
    check("R8 entry9 untouched", tbl_entries[64*9 +: 64], 64'h0000_0000_0001_0000);

    // R3 only the low byte of the select value is kept; 0x40 is past the table
    access(1'b1, 5'd0, 4'hF, 32'h1234_5640, v, e, d);
    access(1'b0, 5'd0, 4'hF, 32'h0, v, e, d);
    check("R3 select low byte", 64'(d), 64'h40);
    access(1'b0, 5'd16, 4'hF, 32'h0, v, e, d);
    check("R10 undefined read zero", 64'(d), 64'h0);
    check("R10 no bus error", 64'(e), 64'h0);
    check("R10 flag set", 64'(undef_err), 64'h1);
    access(1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF, v, e, d);
    check("R10 entry23 after write to 0x40", tbl_entries[64*23 +: 64], 64'h1200_0000_0001_0000);
    access(1'b1, 5'd0, 4'hF, 32'h03, v, e, d);
    access(1'b1, 5'd16, 4'hF, 32'h7700_0000, v, e, d);
    check("R10 unit_id after write to 0x03", 64'(unit_id), 64'hA5);
    check("R10 arb_id after write to 0x03", 64'(arb_id), 64'h3C);
    access(1'b1, 5'd0, 4'hF, 32'h00, v, e, d);
    access(1'b0, 5'd16, 4'hF, 32'h0, v, e, d);
    check("R5 read after undef", 64'(d), 64'hA500_0000);
    check("R10 flag sticky", 64'(undef_err), 64'h1);

    // R4 bad offset write does not reach ID
    access(1'b1, 5'd20, 4'hF, 32'h1100_0000, v, e, d);
    check("R4 error flagged", 64'(e), 64'h1);
    check("R4 unit_id kept", 64'(unit_id), 64'hA5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule